// File: doc/BRIEF.md
# Eigenmode Orbit Feedback Engine

This block turns one vector of beam position readings into one vector of corrector setpoints per feedback cycle. It does not apply an inverse response matrix in one multiply. The readings are projected onto each eigenmode, giving one scalar per mode. Each scalar is scaled by the inverse singular value of its mode and passed through a proportional-integral-derivative compensator of its own. The compensated scalars are then mapped back onto the correctors through the output vectors and summed per corrector.

A cycle begins with a start strobe. The position readings then arrive as a burst, one per accepted beat. After that, the setpoints leave as a burst in corrector order, and a done pulse marks the last one. A start strobe that arrives while a cycle is still in progress is flagged as an overrun and has no other effect. Every coefficient can be rewritten at runtime through a small write port. Arithmetic is signed fixed point, with 2^FRAC (32768 by default) representing 1.0.

The full system has 180 positions and 90 correctors, with one mode per corrector. The defaults are a reduced 6 x 3 size. At 100 MHz the full-size compute tail takes under 1 µs after the last reading, which is well inside the 20 µs budget.

Top module: `ofb_engine`

## Requirements
- R1: For each mode m, the scalar is e[m] = sat(((Σi pos[i]·U[m][i]) >>> FRAC) · isv[m] >>> FRAC). Every shift is arithmetic.
- R2: Each mode has its own compensator. On each cycle it computes integ' = sat(integ + (ki·e >>> FRAC)) and out[m] = sat((kp·e >>> FRAC) + integ' + (kd·(e − prev) >>> FRAC)). It then keeps integ = integ' and prev = e. Both integ and prev start at zero.
- R3: Corrector c receives sp[c] = sat((Σm out[m]·V[c][m]) >>> FRAC).
- R4: sat() clamps to the 20-bit signed range [−524288, 524287]. Integrator states and setpoints stay at the rail and never wrap.
- R5: The setpoint for corrector 0 appears on the third rising edge after the edge that accepts the last position. The setpoints follow on consecutive cycles with sp_index 0, 1, … N_COR−1. cycle_done is high only together with the last one. sp_valid is otherwise low.
- R6: While fb_enable is low, all integrator, previous-error and mode outputs are held at zero, and every setpoint emitted is 0. After enable returns high, the compensators start from zero.
- R7: A cycle_start seen while a cycle is in progress, from collection through the last setpoint, raises overrun for one cycle on the next edge. It does not alter the cycle in progress.
- R8: Write port encodings. cfg_sel 0 writes U[m][i] at address m·N_POS+i. cfg_sel 1 writes V[c][m] at address c·N_COR+m. cfg_sel 2 writes mode parameter k of mode m at address m·4+k, where k is 0 for isv, 1 for kp, 2 for ki and 3 for kd. Writes with cfg_sel 3, and writes to addresses beyond a table's end, change nothing.
- R9: After reset, sp_valid, cycle_done and overrun are low, sp_data is 0, and all coefficients and compensator states are zero.
- R10: A position is taken only on a cycle with pos_valid high during collection, and the i-th accepted beat is pos[i]. Gaps between beats are allowed. pos_valid outside collection is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_enable | input | 1 | Feedback enable; low forces zero compensator state and zero setpoints |
| cycle_start | input | 1 | Start strobe for a feedback cycle |
| pos_valid | input | 1 | Position beat valid |
| pos_data | input | POS_W | Signed position reading |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_sel | input | 2 | Coefficient table select |
| cfg_addr | input | ADDR_W | Entry address within the table |
| cfg_data | input | COEF_W | Signed coefficient value |
| sp_valid | output | 1 | Setpoint beat valid |
| sp_index | output | COR_W | Corrector index of the current setpoint |
| sp_data | output | 20 | Signed setpoint |
| cycle_done | output | 1 | High with the last setpoint of a burst |
| overrun | output | 1 | One-cycle flag for a start strobe that arrived while busy |

## Verification
The setpoint for corrector 0 is due three edges after the edge that takes the last position, and the other setpoints follow on the next N_COR−1 edges. The bench therefore counts falling edges from its last position beat. It requires sp_valid to be low on the first three and to hold the expected index, data and done flag on each of the next N_COR. An overrun flag is due one edge after the offending strobe and is sampled at the falling edge just after it. Expected setpoints come from a bench model of R1–R4 whose integrator and previous-error state is carried from cycle to cycle, so every mismatch in timing or arithmetic shows up at a fixed falling edge.

// File: rtl/ofb_pkg.sv
// Shared types, constants and the saturation helper for the orbit feedback engine.
// Assumes all intermediate products fit in 64 signed bits.
package ofb_pkg;

    localparam int SP_W         = 20;
    localparam int PAR_PER_MODE = 4;

    typedef logic signed [63:0]     wide_t;
    typedef logic signed [SP_W-1:0] sp_t;

    typedef enum logic [1:0] {
        SEL_UROW = 2'd0,
        SEL_VCOL = 2'd1,
        SEL_MODE = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_COLLECT,
        PH_SCALE,
        PH_COMP,
        PH_EMIT
    } phase_e;

    localparam wide_t SP_MAX_W = (wide_t'(1) <<< (SP_W - 1)) - wide_t'(1);
    localparam wide_t SP_MIN_W = -(wide_t'(1) <<< (SP_W - 1));

    // Clamp a wide signed value into the setpoint range.
    function automatic sp_t sat_sp(input wide_t x);
        if (x > SP_MAX_W)
            return sp_t'(SP_MAX_W);
        else if (x < SP_MIN_W)
            return sp_t'(SP_MIN_W);
        else
            return sp_t'(x);
    endfunction

endpackage

// File: rtl/ofb_coef_store.sv
// Coefficient tables: input projection rows, output vectors and per-mode
// parameters (inverse singular value, kp, ki, kd). Written one entry per
// cycle through the write port; reads are parallel. Assumes ADDR_W covers
// the largest table. Unknown selects and out-of-range addresses are dropped.
module ofb_coef_store
    import ofb_pkg::*;
#(
    parameter int N_POS  = 6,
    parameter int N_COR  = 3,
    parameter int COEF_W = 18,
    parameter int ADDR_W = 5,
    localparam int NU    = N_COR * N_POS,
    localparam int NV    = N_COR * N_COR,
    localparam int NP    = N_COR * PAR_PER_MODE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_sel,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic signed [COEF_W-1:0] cfg_data,
    output logic signed [COEF_W-1:0] u_tab   [NU],
    output logic signed [COEF_W-1:0] v_tab   [NV],
    output logic signed [COEF_W-1:0] par_tab [NP]
);

    logic hit_u, hit_v, hit_p;

    // Decode which table the current write targets.
    always_comb begin
        hit_u = cfg_we && (cfg_sel == SEL_UROW);
        hit_v = cfg_we && (cfg_sel == SEL_VCOL);
        hit_p = cfg_we && (cfg_sel == SEL_MODE);
    end

    // Projection-row table update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NU; e++) u_tab[e] <= '0;
        end else begin
            for (int e = 0; e < NU; e++)
                if (hit_u && cfg_addr == ADDR_W'(e)) u_tab[e] <= cfg_data;
        end
    end

    // Output-vector table update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NV; e++) v_tab[e] <= '0;
        end else begin
            for (int e = 0; e < NV; e++)
                if (hit_v && cfg_addr == ADDR_W'(e)) v_tab[e] <= cfg_data;
        end
    end

    // Per-mode parameter table update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NP; e++) par_tab[e] <= '0;
        end else begin
            for (int e = 0; e < NP; e++)
                if (hit_p && cfg_addr == ADDR_W'(e)) par_tab[e] <= cfg_data;
        end
    end

endmodule

// File: rtl/ofb_mode_path.sv
// One eigenmode lane: accumulates the projection of the streamed positions
// onto its row, scales by the inverse singular value, then runs its own
// PID compensator with a saturating integrator. Assumes the sequencer
// pulses acc_clear, pos_fire, do_scale and do_comp in that order.
module ofb_mode_path
    import ofb_pkg::*;
#(
    parameter int N_POS  = 6,
    parameter int POS_W  = 18,
    parameter int COEF_W = 18,
    parameter int FRAC   = 15,
    parameter int IDX_W  = 3,
    parameter int ACC_W  = 40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fb_enable,
    input  logic                     acc_clear,
    input  logic                     pos_fire,
    input  logic [IDX_W-1:0]         pos_idx,
    input  logic signed [POS_W-1:0]  pos_data,
    input  logic signed [COEF_W-1:0] u_row [N_POS],
    input  logic signed [COEF_W-1:0] inv_sv,
    input  logic signed [COEF_W-1:0] kp,
    input  logic signed [COEF_W-1:0] ki,
    input  logic signed [COEF_W-1:0] kd,
    input  logic                     do_scale,
    input  logic                     do_comp,
    output sp_t                      mode_out
);

    logic signed [COEF_W-1:0] u_sel;
    logic signed [ACC_W-1:0]  prod;
    logic signed [ACC_W-1:0]  acc;
    wide_t                    scaled;
    sp_t                      err, integ, prev;
    wide_t                    e_w, p_term, d_term;
    sp_t                      integ_nx, out_nx;

    // Pick the row coefficient matching the current position index.
    always_comb begin
        u_sel = '0;
        for (int i = 0; i < N_POS; i++)
            if (pos_idx == IDX_W'(i)) u_sel = u_row[i];
    end

    assign prod = ACC_W'(pos_data) * ACC_W'(u_sel);

    // Projection accumulator over the position burst.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc <= '0;
        else if (acc_clear) acc <= '0;
        else if (pos_fire)  acc <= acc + prod;
    end

    assign scaled = ((wide_t'(acc) >>> FRAC) * wide_t'(inv_sv)) >>> FRAC;

    // Latch the scaled mode error.
    always_ff @(posedge clk) begin
        if (!rst_n)        err <= '0;
        else if (do_scale) err <= sat_sp(scaled);
    end

    // Compensator arithmetic for the next state and output.
    always_comb begin
        e_w      = wide_t'(err);
        integ_nx = sat_sp(wide_t'(integ) + ((wide_t'(ki) * e_w) >>> FRAC));
        p_term   = (wide_t'(kp) * e_w) >>> FRAC;
        d_term   = (wide_t'(kd) * (e_w - wide_t'(prev))) >>> FRAC;
        out_nx   = sat_sp(p_term + wide_t'(integ_nx) + d_term);
    end

    // Compensator state; forced to zero while feedback is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !fb_enable) begin
            integ    <= '0;
            prev     <= '0;
            mode_out <= '0;
        end else if (do_comp) begin
            integ    <= integ_nx;
            prev     <= err;
            mode_out <= out_nx;
        end
    end

endmodule

// File: rtl/ofb_out_mixer.sv
// Combinational recombination for one corrector: weighted sum of all mode
// outputs by that corrector's output-vector entries, rescaled and clamped.
// Assumes one corrector is evaluated per cycle by the caller.
module ofb_out_mixer
    import ofb_pkg::*;
#(
    parameter int N_COR  = 3,
    parameter int COEF_W = 18,
    parameter int FRAC   = 15
) (
    input  sp_t                      mode_vals [N_COR],
    input  logic signed [COEF_W-1:0] v_row     [N_COR],
    output sp_t                      sp_out
);

    wide_t sum;

    // Dot product of mode outputs with the selected output-vector row.
    always_comb begin
        sum = '0;
        for (int m = 0; m < N_COR; m++)
            sum = sum + wide_t'(mode_vals[m]) * wide_t'(v_row[m]);
    end

    assign sp_out = sat_sp(sum >>> FRAC);

endmodule

// File: rtl/ofb_engine.sv
// Eigenmode orbit feedback engine top. Sequences one feedback cycle:
// collect positions, scale, compensate, then emit one setpoint per cycle.
// Assumes positions are streamed only after cycle_start is accepted.
module ofb_engine
    import ofb_pkg::*;
#(
    parameter int N_POS    = 6,
    parameter int N_COR    = 3,
    parameter int POS_W    = 18,
    parameter int COEF_W   = 18,
    parameter int FRAC     = 15,
    localparam int NU      = N_COR * N_POS,
    localparam int NV      = N_COR * N_COR,
    localparam int NP      = N_COR * PAR_PER_MODE,
    localparam int TAB_A   = (NU > NV) ? NU : NV,
    localparam int TAB_MAX = (TAB_A > NP) ? TAB_A : NP,
    localparam int ADDR_W  = (TAB_MAX > 2) ? $clog2(TAB_MAX) : 1,
    localparam int IDX_W   = (N_POS > 1) ? $clog2(N_POS) : 1,
    localparam int COR_W   = (N_COR > 1) ? $clog2(N_COR) : 1,
    localparam int ACC_W   = POS_W + COEF_W + IDX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fb_enable,
    input  logic                     cycle_start,
    input  logic                     pos_valid,
    input  logic signed [POS_W-1:0]  pos_data,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_sel,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic signed [COEF_W-1:0] cfg_data,
    output logic                     sp_valid,
    output logic [COR_W-1:0]         sp_index,
    output logic signed [SP_W-1:0]   sp_data,
    output logic                     cycle_done,
    output logic                     overrun
);

    logic signed [COEF_W-1:0] u_tab   [NU];
    logic signed [COEF_W-1:0] v_tab   [NV];
    logic signed [COEF_W-1:0] par_tab [NP];
    sp_t                      mode_vals [N_COR];
    logic signed [COEF_W-1:0] v_row   [N_COR];
    sp_t                      mix_out;

    phase_e            phase;
    logic [IDX_W-1:0]  pos_idx;
    logic [COR_W-1:0]  cor_idx;
    logic              acc_clear, pos_fire, do_scale, do_comp, emitting, last_cor;

    ofb_coef_store #(
        .N_POS  (N_POS),
        .N_COR  (N_COR),
        .COEF_W (COEF_W),
        .ADDR_W (ADDR_W)
    ) coef_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .u_tab    (u_tab),
        .v_tab    (v_tab),
        .par_tab  (par_tab)
    );

    // Sequencer strobes derived from the current phase.
    always_comb begin
        acc_clear = (phase == PH_IDLE) && cycle_start;
        pos_fire  = (phase == PH_COLLECT) && pos_valid;
        do_scale  = (phase == PH_SCALE);
        do_comp   = (phase == PH_COMP);
        emitting  = (phase == PH_EMIT);
        last_cor  = (cor_idx == COR_W'(N_COR - 1));
    end

    for (genvar m = 0; m < N_COR; m++) begin : g_mode
        logic signed [COEF_W-1:0] row [N_POS];

        // Slice this mode's projection row out of the flat table.
        always_comb begin
            for (int i = 0; i < N_POS; i++) row[i] = u_tab[m * N_POS + i];
        end

        ofb_mode_path #(
            .N_POS  (N_POS),
            .POS_W  (POS_W),
            .COEF_W (COEF_W),
            .FRAC   (FRAC),
            .IDX_W  (IDX_W),
            .ACC_W  (ACC_W)
        ) lane_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .fb_enable (fb_enable),
            .acc_clear (acc_clear),
            .pos_fire  (pos_fire),
            .pos_idx   (pos_idx),
            .pos_data  (pos_data),
            .u_row     (row),
            .inv_sv    (par_tab[m * PAR_PER_MODE + 0]),
            .kp        (par_tab[m * PAR_PER_MODE + 1]),
            .ki        (par_tab[m * PAR_PER_MODE + 2]),
            .kd        (par_tab[m * PAR_PER_MODE + 3]),
            .do_scale  (do_scale),
            .do_comp   (do_comp),
            .mode_out  (mode_vals[m])
        );
    end

    // Select the output-vector row of the corrector being emitted.
    always_comb begin
        for (int m = 0; m < N_COR; m++) begin
            v_row[m] = '0;
            for (int c = 0; c < N_COR; c++)
                if (cor_idx == COR_W'(c)) v_row[m] = v_tab[c * N_COR + m];
        end
    end

    ofb_out_mixer #(
        .N_COR  (N_COR),
        .COEF_W (COEF_W),
        .FRAC   (FRAC)
    ) mix_i (
        .mode_vals (mode_vals),
        .v_row     (v_row),
        .sp_out    (mix_out)
    );

    // Cycle phase machine with position and corrector counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            pos_idx <= '0;
            cor_idx <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    pos_idx <= '0;
                    if (cycle_start) phase <= PH_COLLECT;
                end
                PH_COLLECT: begin
                    if (pos_valid) begin
                        if (pos_idx == IDX_W'(N_POS - 1)) phase <= PH_SCALE;
                        else pos_idx <= pos_idx + 1'b1;
                    end
                end
                PH_SCALE: phase <= PH_COMP;
                PH_COMP: begin
                    phase   <= PH_EMIT;
                    cor_idx <= '0;
                end
                PH_EMIT: begin
                    if (last_cor) begin
                        phase   <= PH_IDLE;
                        cor_idx <= '0;
                    end else begin
                        cor_idx <= cor_idx + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Registered setpoint stream, done marker and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_valid   <= 1'b0;
            sp_index   <= '0;
            sp_data    <= '0;
            cycle_done <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            sp_valid   <= emitting;
            cycle_done <= emitting && last_cor;
            overrun    <= cycle_start && (phase != PH_IDLE);
            if (emitting) begin
                sp_index <= cor_idx;
                sp_data  <= mix_out;
            end
        end
    end

endmodule

// File: rtl/ofb_engine_chk.sv
// Protocol checker for the orbit feedback engine, bound to every instance.
// Assumes the setpoint stream and flags are the only observed behaviour.
module ofb_engine_chk
    import ofb_pkg::*;
#(
    parameter int COR_W = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   fb_enable,
    input logic                   cycle_start,
    input logic                   sp_valid,
    input logic [COR_W-1:0]       sp_index,
    input logic signed [SP_W-1:0] sp_data,
    input logic                   cycle_done,
    input logic                   overrun
);

    AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> sp_valid);                                          // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);                                       // R5

    AST_FIRST_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sp_valid) |-> (sp_index == '0));                             // R5

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_valid && !cycle_done) |=> (sp_valid && sp_index == COR_W'($past(sp_index) + 1'b1))); // R5

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(cycle_start));                                   // R7

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_valid && !$past(fb_enable, 2)) |-> (sp_data == '0));           // R6

endmodule

bind ofb_engine ofb_engine_chk #(.COR_W(COR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fb_enable   (fb_enable),
    .cycle_start (cycle_start),
    .sp_valid    (sp_valid),
    .sp_index    (sp_index),
    .sp_data     (sp_data),
    .cycle_done  (cycle_done),
    .overrun     (overrun)
);

// File: tb/ofb_engine_tb_top.sv
// Self-checking bench: seeded random coefficients and positions plus
// directed saturation, disable, overrun and ignored-write cases.
module ofb_engine_tb_top;

    localparam int N_POS  = 6;
    localparam int N_COR  = 3;
    localparam int POS_W  = 18;
    localparam int COEF_W = 18;
    localparam int FRAC   = 15;
    localparam int ADDR_W = $clog2(N_COR * N_POS);
    localparam int COR_W  = $clog2(N_COR);
    localparam longint SMAX = 524287;
    localparam longint SMIN = -524288;
    localparam longint ONE  = 32768;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     fb_enable = 1'b1;
    logic                     cycle_start = 1'b0;
    logic                     pos_valid = 1'b0;
    logic signed [POS_W-1:0]  pos_data = '0;
    logic                     cfg_we = 1'b0;
    logic [1:0]               cfg_sel = '0;
    logic [ADDR_W-1:0]        cfg_addr = '0;
    logic signed [COEF_W-1:0] cfg_data = '0;
    logic                     sp_valid;
    logic [COR_W-1:0]         sp_index;
    logic signed [19:0]       sp_data;
    logic                     cycle_done;
    logic                     overrun;

    always #5 clk = ~clk;

    ofb_engine #(
        .N_POS(N_POS), .N_COR(N_COR), .POS_W(POS_W), .COEF_W(COEF_W), .FRAC(FRAC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .fb_enable(fb_enable), .cycle_start(cycle_start),
        .pos_valid(pos_valid), .pos_data(pos_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .sp_valid(sp_valid), .sp_index(sp_index),
        .sp_data(sp_data), .cycle_done(cycle_done), .overrun(overrun)
    );

    int checks = 0;
    int failures = 0;

    longint mu [N_COR][N_POS];
    longint mv [N_COR][N_COR];
    longint misv [N_COR], mkp [N_COR], mki [N_COR], mkd [N_COR];
    longint minteg [N_COR], mprev [N_COR];
    longint exp_sp [N_COR];
    longint got_sp [N_COR];

    function automatic longint sat(longint x);
        if (x > SMAX) return SMAX;
        if (x < SMIN) return SMIN;
        return x;
    endfunction

    function automatic longint rnd(longint lo, longint hi);
        return lo + longint'($urandom % 32'(hi - lo + 1));
    endfunction

    task automatic check(string tag, longint act, longint expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic cfg_write(int sel, int addr, longint val);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = ADDR_W'(addr); cfg_data = COEF_W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_u(int m, int i, longint val);
        cfg_write(0, m * N_POS + i, val); mu[m][i] = val;
    endtask

    task automatic set_v(int c, int m, longint val);
        cfg_write(1, c * N_COR + m, val); mv[c][m] = val;
    endtask

    task automatic set_mode(int m, longint isv, longint kp, longint ki, longint kd);
        cfg_write(2, m * 4 + 0, isv); misv[m] = isv;
        cfg_write(2, m * 4 + 1, kp);  mkp[m]  = kp;
        cfg_write(2, m * 4 + 2, ki);  mki[m]  = ki;
        cfg_write(2, m * 4 + 3, kd);  mkd[m]  = kd;
    endtask

    // Reference model of R1..R4 and R6 for one feedback cycle.
    task automatic predict(input longint pos [N_POS], input bit fb);
        longint outm [N_COR];
        for (int m = 0; m < N_COR; m++) begin
            longint acc = 0;
            longint e, in_nx;
            for (int i = 0; i < N_POS; i++) acc += pos[i] * mu[m][i];
            e = sat(((acc >>> FRAC) * misv[m]) >>> FRAC);
            if (fb) begin
                in_nx = sat(minteg[m] + ((mki[m] * e) >>> FRAC));
                outm[m] = sat(((mkp[m] * e) >>> FRAC) + in_nx + ((mkd[m] * (e - mprev[m])) >>> FRAC));
                minteg[m] = in_nx;
                mprev[m] = e;
            end else begin
                outm[m] = 0; minteg[m] = 0; mprev[m] = 0;
            end
        end
        for (int c = 0; c < N_COR; c++) begin
            longint s = 0;
            for (int m = 0; m < N_COR; m++) s += outm[m] * mv[c][m];
            exp_sp[c] = sat(s >>> FRAC);
        end
    endtask

    // Drive one cycle and check timing (R5), data (R1-R4, R6), overrun (R7), gaps (R10).
    task automatic run_cycle(input longint pos [N_POS], input bit fb, input int gap,
                             input bit stray, input bit ovr, input string tag);
        fb_enable = fb;
        if (stray) begin
            pos_valid = 1'b1; pos_data = '1;
            @(negedge clk);
            pos_valid = 1'b0;
        end
        predict(pos, fb);
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        for (int i = 0; i < N_POS; i++) begin
            for (int g = 0; g < ((i % 2 == 1) ? gap : 0); g++) begin
                pos_valid = 1'b0; pos_data = 18'sh1555;
                @(negedge clk);
            end
            pos_valid = 1'b1; pos_data = POS_W'(pos[i]);
            @(negedge clk);
        end
        pos_valid = 1'b0;
        check({tag, " R5 quiet n1"}, longint'(sp_valid), 0);
        if (ovr) cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        check({tag, " R7 overrun flag"}, longint'(overrun), longint'(ovr));
        check({tag, " R5 quiet n2"}, longint'(sp_valid), 0);
        if (ovr) begin pos_valid = 1'b1; pos_data = 18'sh1FFFF; end
        @(negedge clk);
        pos_valid = 1'b0;
        check({tag, " R5 quiet n3"}, longint'(sp_valid), 0);
        @(negedge clk);
        for (int c = 0; c < N_COR; c++) begin
            got_sp[c] = longint'(sp_data);
            check({tag, " R5 valid"}, longint'(sp_valid), 1);
            check({tag, " R5 index"}, longint'(sp_index), longint'(c));
            check({tag, " R5 done"}, longint'(cycle_done), longint'(c == N_COR - 1));
            check({tag, " R3 setpoint"}, got_sp[c], exp_sp[c]);
            @(negedge clk);
        end
        check({tag, " R5 burst end"}, longint'(sp_valid), 0);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        longint pos [N_POS];
        void'($urandom(32'd4242));
        for (int m = 0; m < N_COR; m++) begin
            misv[m] = 0; mkp[m] = 0; mki[m] = 0; mkd[m] = 0; minteg[m] = 0; mprev[m] = 0;
            for (int i = 0; i < N_POS; i++) mu[m][i] = 0;
            for (int c = 0; c < N_COR; c++) mv[c][m] = 0;
        end
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 sp_valid", longint'(sp_valid), 0);
        check("R9 sp_data", longint'(sp_data), 0);
        check("R9 cycle_done", longint'(cycle_done), 0);
        check("R9 overrun", longint'(overrun), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release", longint'(sp_valid), 0);

        // R9: zero coefficients give zero setpoints
        for (int i = 0; i < N_POS; i++) pos[i] = rnd(-4000, 4000);
        run_cycle(pos, 1'b1, 0, 1'b0, 1'b0, "R9 zero coef");

        // R8: load random coefficients through the write port
        for (int m = 0; m < N_COR; m++) begin
            for (int i = 0; i < N_POS; i++) set_u(m, i, rnd(-16384, 16384));
            for (int c = 0; c < N_COR; c++) set_v(c, m, rnd(-16384, 16384));
            set_mode(m, rnd(16384, 32767), rnd(-20000, 20000), rnd(-8000, 8000), rnd(-8000, 8000));
        end

        // R1 R2 R3 R10: random cycles, some with gaps and stray beats
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < N_POS; i++) pos[i] = rnd(-4096, 4096);
            run_cycle(pos, 1'b1, k % 3, k % 2 == 1, 1'b0, "R1 R2 R10 random");
        end

        // R8: writes with select 3 and out-of-range addresses are ignored
        cfg_write(3, 0, 12345);
        cfg_write(1, 31, 777);
        cfg_write(2, 31, -999);
        for (int i = 0; i < N_POS; i++) pos[i] = rnd(-4096, 4096);
        run_cycle(pos, 1'b1, 1, 1'b0, 1'b0, "R8 ignored writes");

        // R6: disabled feedback gives zero setpoints, then restart from zero state
        run_cycle(pos, 1'b0, 0, 1'b0, 1'b0, "R6 disabled");
        for (int c = 0; c < N_COR; c++) check("R6 zero output", got_sp[c], 0);
        run_cycle(pos, 1'b1, 0, 1'b0, 1'b0, "R6 re-enabled");

        // R7: start strobe while busy is flagged and ignored
        for (int i = 0; i < N_POS; i++) pos[i] = rnd(-4096, 4096);
        run_cycle(pos, 1'b1, 0, 1'b0, 1'b1, "R7 busy start");
        for (int i = 0; i < N_POS; i++) pos[i] = rnd(-4096, 4096);
        run_cycle(pos, 1'b1, 2, 1'b1, 1'b0, "R7 after overrun");

        // R4: proportional path drives setpoints to both rails
        for (int m = 0; m < N_COR; m++) begin
            for (int i = 0; i < N_POS; i++) set_u(m, i, ONE);
            for (int c = 0; c < N_COR; c++) set_v(c, m, ONE);
            set_mode(m, ONE, ONE, 0, 0);
        end
        run_cycle(pos, 1'b0, 0, 1'b0, 1'b0, "R4 clear state");
        for (int i = 0; i < N_POS; i++) pos[i] = 131071;
        run_cycle(pos, 1'b1, 0, 1'b0, 1'b0, "R4 positive");
        for (int c = 0; c < N_COR; c++) check("R4 upper clamp", got_sp[c], SMAX);
        for (int i = 0; i < N_POS; i++) pos[i] = -131072;
        run_cycle(pos, 1'b1, 0, 1'b0, 1'b0, "R4 negative");
        for (int c = 0; c < N_COR; c++) check("R4 lower clamp", got_sp[c], SMIN);

        // R4: integrator alone winds up to the rail and stays there
        for (int m = 0; m < N_COR; m++) begin
            for (int c = 0; c < N_COR; c++) set_v(c, m, (c == m) ? ONE : 0);
            set_mode(m, ONE, 0, ONE, 0);
        end
        run_cycle(pos, 1'b0, 0, 1'b0, 1'b0, "R4 clear integ");
        for (int i = 0; i < N_POS; i++) pos[i] = 20000;
        for (int k = 0; k < 7; k++) run_cycle(pos, 1'b1, 0, 1'b0, 1'b0, "R4 integ windup");
        for (int c = 0; c < N_COR; c++) check("R4 integ rail", got_sp[c], SMAX);
        for (int i = 0; i < N_POS; i++) pos[i] = -1;
        run_cycle(pos, 1'b1, 0, 1'b0, 1'b0, "R4 integ unwind");
        for (int c = 0; c < N_COR; c++) check("R4 no wrap", longint'(got_sp[c] > 500000), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule